// File: doc/BRIEF.md
# Fetch-Side Two-Entry Address Translation Cache

This block sits right after the multiplexer that picks the next instruction fetch address. It turns that effective address into a real address within the same cycle. Two fully associative slots each pair an effective page number with a real page number, using a 4 KiB page, so the low twelve address bits pass straight through. When translation is off, the effective address is forwarded unchanged. When translation is on and the page hits a slot, the fetch request goes out at once with the translated page.

When translation is on and neither slot matches, the block withdraws the request and reads a direct-mapped 64-entry instruction TLB held inside it. That read costs two cycles without a request. If the TLB entry is usable, it goes into the least recently used slot, and the fetch unit, which holds its address while no request is issued, hits on the next try. If the TLB has no match or the entry forbids execution, a fetch-failed flag is raised and held. The flag stays up until a page table entry is delivered on the fill port or until a redirect or interrupt arrives. Page table entries always update the TLB. An invalidate request empties both slots and the whole TLB.

Top module: `fetch_xlate_cache`

## Requirements
- R1: After reset both slots and all TLB entries are invalid, the replacement pointer selects slot 0, `req_out` is 0 and `fetch_fail` is 0.
- R2: When idle with `fa_req` high and `xlate_en` low, `req_out` is 1 in the same cycle, `ra_out` equals `fa_ea`, and no lookup starts.
- R3: When idle with `fa_req` and `xlate_en` high and the page number `fa_ea[31:12]` matching a valid slot, `req_out` is 1 in the same cycle and `ra_out` is that slot's real page number followed by `fa_ea[11:0]`.
- R4: On a slot miss with translation on, `req_out` is 0 in the miss cycle and in the next cycle. If the TLB holds a matching executable entry, the slot is loaded, and the same address presented in the third cycle hits.
- R5: A fill (from the TLB or from the fill port) writes the slot named by the replacement pointer and then points it at the other slot. A hit on slot k points it at the other slot.
- R6: The TLB index is the XOR fold of the 20-bit page number: page bit i feeds index bit i mod 6. Each entry keeps the full page number as tag, so a later write whose page number has the same index replaces the earlier one, and a lookup of the earlier page then faults.
- R7: A TLB lookup with no tag match, or with the no-execute bit set, raises `fetch_fail` from the cycle after the lookup cycle. `req_out` stays 0 and the flag holds until R8 or R9 releases it.
- R8: While failed, a fill-port write with `pte_noexec` = 0 loads the TLB and the replacement slot, and the block is idle in the next cycle. A write with `pte_noexec` = 1 only loads the TLB, and the failure stays.
- R9: `redirect` or `intr` during a lookup or failure returns the block to idle in the next cycle without loading a slot. In the idle state they have no effect.
- R10: `inval` clears both slots and every TLB entry, takes precedence over a fill-port write in the same cycle, aborts a lookup in progress, and keeps a miss in the same cycle from starting a lookup.
- R11: A fill-port write outside the failed state updates only the TLB. The slots are untouched, so the page still misses first and then hits after the two-cycle lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fa_req | input | 1 | Fetch unit wants a translation this cycle |
| fa_ea | input | 32 | Next effective fetch address |
| xlate_en | input | 1 | Instruction address translation enabled |
| req_out | output | 1 | Real address valid, fetch may proceed |
| ra_out | output | 32 | Real fetch address |
| fetch_fail | output | 1 | TLB miss or no-execute fault, fetch stalled |
| inval | input | 1 | Invalidate all slots and the whole TLB |
| redirect | input | 1 | Branch redirect, abandons lookup or failure |
| intr | input | 1 | Interrupt, abandons lookup or failure |
| pte_we | input | 1 | Page table entry delivery strobe |
| pte_pn | input | 20 | Effective page number of the delivered entry |
| pte_rpn | input | 20 | Real page number of the delivered entry |
| pte_noexec | input | 1 | Delivered entry forbids instruction fetch |

## Verification
The hardest case to reach from the ports is a collision in the TLB index. Two different pages must fold to the same index, the second must be written while the first still sits in a slot, and then an invalidate must force a fresh lookup of the first page. Only then does the tag compare in the lookup cycle fail. The stimulus builds this by choosing a second page whose middle and upper six-bit groups cancel under the fold. It follows that with a no-execute delivery that leaves the failure in place, a redirect during the lookup cycle itself, and an invalidate that lands together with a fill-port write. A pseudo-random phase then mixes holds, fills and aborts against the behavioural model on every clock.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PN_W       = ADDR_W - PAGE_SHIFT;

    typedef logic [PN_W-1:0] pn_t;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_LOOK  = 2'd1,
        XS_FAULT = 2'd2
    } xstate_e;

    typedef struct packed {
        logic valid;
        pn_t  epn;
        pn_t  rpn;
    } slot_t;

    typedef struct packed {
        pn_t  tag;
        pn_t  rpn;
        logic noexec;
    } tlb_word_t;

    function automatic logic slot_hit(input slot_t s, input pn_t pn);
        return s.valid && (s.epn == pn);
    endfunction

endpackage

// File: rtl/fxc_tlb.sv
module fxc_tlb
    import fxc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr_all,
    input  logic      wr_en,
    input  pn_t       wr_pn,
    input  pn_t       wr_rpn,
    input  logic      wr_noexec,
    input  logic      rd_en,
    input  pn_t       rd_pn,
    output logic      rd_valid,
    output tlb_word_t rd_word
);
    localparam int DEPTH = 1 << IDX_W;

    function automatic logic [IDX_W-1:0] fold(input pn_t pn);
        logic [IDX_W-1:0] h;
        pn_t              rest;
        h    = '0;
        rest = pn;
        for (int k = 0; k < PN_W; k += IDX_W) begin
            h    = h ^ rest[IDX_W-1:0];
            rest = rest >> IDX_W;
        end
        return h;
    endfunction

    tlb_word_t        mem [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [IDX_W-1:0] widx, ridx;

    assign widx = fold(wr_pn);
    assign ridx = fold(rd_pn);

    always_ff @(posedge clk) begin
        if (wr_en && !clr_all) begin
            mem[widx] <= '{tag: wr_pn, rpn: wr_rpn, noexec: wr_noexec};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[widx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else if (rd_en) begin
            rd_valid <= vld_q[ridx];
            rd_word  <= mem[ridx];
        end
    end

endmodule

// File: rtl/fxc_pair.sv
module fxc_pair
    import fxc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pn_t  look_pn,
    input  logic clr,
    input  logic touch,
    input  logic fill_en,
    input  pn_t  fill_epn,
    input  pn_t  fill_rpn,
    output logic hit,
    output logic hit_sel,
    output pn_t  hit_rpn,
    output logic lru_sel
);
    logic [1:0]           match;
    logic [1:0][PN_W-1:0] slot_rpn;

    for (genvar g = 0; g < 2; g++) begin : g_slot
        slot_t slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (clr) begin
                slot_q.valid <= 1'b0;
            end else if (fill_en && (lru_sel == 1'(g))) begin
                slot_q <= '{valid: 1'b1, epn: fill_epn, rpn: fill_rpn};
            end
        end

        assign match[g]    = slot_hit(slot_q, look_pn);
        assign slot_rpn[g] = slot_q.rpn;
    end

    assign hit     = |match;
    assign hit_sel = match[1] && !match[0];
    assign hit_rpn = slot_rpn[hit_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_sel <= 1'b0;
        end else if (fill_en) begin
            lru_sel <= !lru_sel;
        end else if (touch) begin
            lru_sel <= !hit_sel;
        end
    end

endmodule

// File: rtl/fxc_ctrl.sv
module fxc_ctrl
    import fxc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fa_req,
    input  logic    xlate_en,
    input  logic    hit,
    input  logic    tlb_ok,
    input  logic    inval,
    input  logic    abandon,
    input  logic    pte_we,
    input  logic    pte_noexec,
    output xstate_e st,
    output logic    take,
    output logic    touch,
    output logic    start_look,
    output logic    look_fill,
    output logic    pte_fill
);
    xstate_e st_nx;

    assign take       = (st == XS_IDLE) && fa_req;
    assign touch      = take && xlate_en && hit;
    assign start_look = take && xlate_en && !hit && !inval;
    assign look_fill  = (st == XS_LOOK) && !abandon && !inval && tlb_ok;
    assign pte_fill   = (st == XS_FAULT) && !abandon && !inval && pte_we && !pte_noexec;

    always_comb begin
        st_nx = st;
        case (st)
            XS_IDLE:  if (start_look) st_nx = XS_LOOK;
            XS_LOOK:  begin
                if (abandon || inval || tlb_ok) st_nx = XS_IDLE;
                else                            st_nx = XS_FAULT;
            end
            XS_FAULT: if (abandon || pte_fill) st_nx = XS_IDLE;
            default:  st_nx = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= XS_IDLE;
        else     st <= st_nx;
    end

endmodule

// File: rtl/fetch_xlate_cache.sv
module fetch_xlate_cache
    import fxc_pkg::*;
#(
    parameter int TLB_IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fa_req,
    input  logic [ADDR_W-1:0] fa_ea,
    input  logic              xlate_en,
    output logic              req_out,
    output logic [ADDR_W-1:0] ra_out,
    output logic              fetch_fail,
    input  logic              inval,
    input  logic              redirect,
    input  logic              intr,
    input  logic              pte_we,
    input  logic [PN_W-1:0]   pte_pn,
    input  logic [PN_W-1:0]   pte_rpn,
    input  logic              pte_noexec
);
    xstate_e   st;
    pn_t       ea_pn, pend_pn, hit_rpn, fill_epn, fill_rpn;
    logic      hit, hit_sel, lru_sel;
    logic      take, touch, start_look, look_fill, pte_fill, tlb_ok;
    logic      rd_valid;
    tlb_word_t rd_word;

    assign ea_pn = fa_ea[ADDR_W-1:PAGE_SHIFT];

    always_ff @(posedge clk) begin
        if (rst)             pend_pn <= '0;
        else if (start_look) pend_pn <= ea_pn;
    end

    assign tlb_ok = rd_valid && (rd_word.tag == pend_pn) && !rd_word.noexec;

    fxc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fa_req     (fa_req),
        .xlate_en   (xlate_en),
        .hit        (hit),
        .tlb_ok     (tlb_ok),
        .inval      (inval),
        .abandon    (redirect || intr),
        .pte_we     (pte_we),
        .pte_noexec (pte_noexec),
        .st         (st),
        .take       (take),
        .touch      (touch),
        .start_look (start_look),
        .look_fill  (look_fill),
        .pte_fill   (pte_fill)
    );

    fxc_tlb #(.IDX_W(TLB_IDX_W)) u_tlb (
        .clk       (clk),
        .rst       (rst),
        .clr_all   (inval),
        .wr_en     (pte_we),
        .wr_pn     (pte_pn),
        .wr_rpn    (pte_rpn),
        .wr_noexec (pte_noexec),
        .rd_en     (start_look),
        .rd_pn     (ea_pn),
        .rd_valid  (rd_valid),
        .rd_word   (rd_word)
    );

    assign fill_epn = look_fill ? pend_pn     : pte_pn;
    assign fill_rpn = look_fill ? rd_word.rpn : pte_rpn;

    fxc_pair u_pair (
        .clk      (clk),
        .rst      (rst),
        .look_pn  (ea_pn),
        .clr      (inval),
        .touch    (touch),
        .fill_en  (look_fill || pte_fill),
        .fill_epn (fill_epn),
        .fill_rpn (fill_rpn),
        .hit      (hit),
        .hit_sel  (hit_sel),
        .hit_rpn  (hit_rpn),
        .lru_sel  (lru_sel)
    );

    assign req_out    = take && (!xlate_en || hit);
    assign ra_out     = xlate_en ? {hit_rpn, fa_ea[PAGE_SHIFT-1:0]} : fa_ea;
    assign fetch_fail = (st == XS_FAULT);

endmodule

// File: rtl/fxc_chk.sv
module fxc_chk
    import fxc_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    fa_req,
    input logic    xlate_en,
    input logic    req_out,
    input logic    fetch_fail,
    input logic    inval,
    input logic    redirect,
    input logic    intr,
    input logic    pte_we,
    input xstate_e st,
    input logic    hit,
    input logic    hit_sel,
    input logic    lru_sel
);
    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        (st == XS_IDLE && fa_req && !xlate_en) |-> req_out);

    p_miss_enters_look_r4: assert property (@(posedge clk) disable iff (rst)
        (st == XS_IDLE && fa_req && xlate_en && !hit && !inval) |=> (st == XS_LOOK && !req_out));

    p_look_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (st == XS_LOOK) |-> (!req_out && !fetch_fail));

    p_touch_flips_r5: assert property (@(posedge clk) disable iff (rst)
        (st == XS_IDLE && fa_req && xlate_en && hit) |=> (lru_sel != $past(hit_sel)));

    p_fail_blocks_req_r7: assert property (@(posedge clk) disable iff (rst)
        fetch_fail |-> !req_out);

    p_fail_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (fetch_fail && !redirect && !intr && !pte_we) |=> fetch_fail);

    p_escape_r9: assert property (@(posedge clk) disable iff (rst)
        (st != XS_IDLE && (redirect || intr)) |=> (st == XS_IDLE && !fetch_fail));

    p_inval_empties_r10: assert property (@(posedge clk) disable iff (rst)
        inval |=> !(req_out && xlate_en));

endmodule

bind fetch_xlate_cache fxc_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .fa_req     (fa_req),
    .xlate_en   (xlate_en),
    .req_out    (req_out),
    .fetch_fail (fetch_fail),
    .inval      (inval),
    .redirect   (redirect),
    .intr       (intr),
    .pte_we     (pte_we),
    .st         (st),
    .hit        (hit),
    .hit_sel    (hit_sel),
    .lru_sel    (lru_sel)
);

// File: tb/test_fetch_xlate_cache.sv
`timescale 1ns/1ps
module test_fetch_xlate_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fa_req = 1'b0, xlate_en = 1'b0;
    logic [31:0] fa_ea = '0;
    logic        req_out, fetch_fail;
    logic [31:0] ra_out;
    logic        inval = 1'b0, redirect = 1'b0, intr = 1'b0;
    logic        pte_we = 1'b0, pte_noexec = 1'b0;
    logic [19:0] pte_pn = '0, pte_rpn = '0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fetch_xlate_cache i_fetch_xlate_cache (
        .clk(clk), .rst(rst), .fa_req(fa_req), .fa_ea(fa_ea), .xlate_en(xlate_en),
        .req_out(req_out), .ra_out(ra_out), .fetch_fail(fetch_fail),
        .inval(inval), .redirect(redirect), .intr(intr),
        .pte_we(pte_we), .pte_pn(pte_pn), .pte_rpn(pte_rpn), .pte_noexec(pte_noexec)
    );

    // behavioural reference state
    bit          m_v [2];
    logic [19:0] m_e [2];
    logic [19:0] m_r [2];
    int          m_lru, m_mode;           // mode 0 idle, 1 lookup, 2 failed
    bit          t_v [64];
    logic [19:0] t_tag [64];
    logic [19:0] t_rpn [64];
    bit          t_nx [64];
    bit          rd_v, rd_nx;
    logic [19:0] rd_tag, rd_rpn, pend;
    bit          last_req;

    function automatic int hidx(input logic [19:0] pn);
        int h = 0;
        for (int i = 0; i < 20; i++) if (pn[i]) h = h ^ (1 << (i % 6));
        return h;
    endfunction

    task automatic model_reset();
        m_v[0] = 0; m_v[1] = 0; m_lru = 0; m_mode = 0; rd_v = 0;
        for (int i = 0; i < 64; i++) t_v[i] = 0;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        logic [19:0] pn, fe, fr;
        int          hi, nmode, k;
        bit          ex_req, ex_fail, redir, fill;
        logic [31:0] ex_ra;
        string       t;
        #1;
        pn = fa_ea[31:12];
        hi = -1;
        if (m_v[0] && m_e[0] == pn)      hi = 0;
        else if (m_v[1] && m_e[1] == pn) hi = 1;
        ex_req = 0; ex_ra = fa_ea;
        if (m_mode == 0 && fa_req) begin
            if (!xlate_en) ex_req = 1;
            else if (hi >= 0) begin ex_req = 1; ex_ra = {m_r[hi], fa_ea[11:0]}; end
        end
        ex_fail = (m_mode == 2);
        t = tag;
        if (t == "") t = (m_mode == 2) ? "R7" : (m_mode == 1) ? "R4" : !xlate_en ? "R2" : "R3";
        chk(t, "req_out", {31'b0, req_out}, {31'b0, ex_req});
        if (ex_req) chk(t, "ra_out", ra_out, ex_ra);
        chk(t, "fetch_fail", {31'b0, fetch_fail}, {31'b0, ex_fail});
        last_req = req_out;
        // advance the reference by one clock
        redir = redirect || intr;
        nmode = m_mode; fill = 0; fe = '0; fr = '0;
        if (m_mode == 0) begin
            if (fa_req && xlate_en && hi >= 0) m_lru = 1 - hi;
            if (fa_req && xlate_en && hi < 0 && !inval) begin
                k = hidx(pn);
                rd_v = t_v[k]; rd_tag = t_tag[k]; rd_rpn = t_rpn[k]; rd_nx = t_nx[k];
                pend = pn; nmode = 1;
            end
        end else if (m_mode == 1) begin
            if (redir || inval) nmode = 0;
            else if (rd_v && rd_tag == pend && !rd_nx) begin fill = 1; fe = pend; fr = rd_rpn; nmode = 0; end
            else nmode = 2;
        end else begin
            if (redir) nmode = 0;
            else if (pte_we && !inval && !pte_noexec) begin fill = 1; fe = pte_pn; fr = pte_rpn; nmode = 0; end
        end
        if (fill) begin m_v[m_lru] = 1; m_e[m_lru] = fe; m_r[m_lru] = fr; m_lru = 1 - m_lru; end
        if (inval) begin
            m_v[0] = 0; m_v[1] = 0;
            for (int i = 0; i < 64; i++) t_v[i] = 0;
        end else if (pte_we) begin
            k = hidx(pte_pn);
            t_v[k] = 1; t_tag[k] = pte_pn; t_rpn[k] = pte_rpn; t_nx[k] = pte_noexec;
        end
        m_mode = nmode;
        @(negedge clk);
    endtask

    task automatic quiet();
        fa_req = 0; inval = 0; redirect = 0; intr = 0; pte_we = 0; pte_noexec = 0;
    endtask

    task automatic fetch(input logic [19:0] pn, input logic [11:0] off, input int n, input string tag);
        fa_req = 1; fa_ea = {pn, off};
        for (int i = 0; i < n; i++) step(tag);
        fa_req = 0;
    endtask

    task automatic pte(input logic [19:0] pn, input logic [19:0] rpn, input bit nx, input string tag);
        pte_we = 1; pte_pn = pn; pte_rpn = rpn; pte_noexec = nx;
        step(tag);
        pte_we = 0; pte_noexec = 0;
    endtask

    localparam logic [19:0] PA = 20'h00010, PB = 20'h00020, PC = 20'h00030;
    localparam logic [19:0] PD = 20'h05150;   // folds onto the same TLB index as PA

    initial begin : main
        int lows;
        logic [15:0] lfsr;
        logic [19:0] pages [6];
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: empty after reset, first translated fetch misses
        xlate_en = 1;
        chk("R1", "req_out", {31'b0, req_out}, 32'd0);
        chk("R1", "fetch_fail", {31'b0, fetch_fail}, 32'd0);
        fetch(PA, 12'h104, 1, "R1");
        // R7: empty TLB -> lookup then hold failure
        fetch(PA, 12'h104, 1, "R4");
        fetch(PA, 12'h104, 3, "R7");
        chk("R7", "fail held", {31'b0, fetch_fail}, 32'd1);
        // R8: delivery releases, then hit
        fa_req = 1; fa_ea = {PA, 12'h104};
        pte(PA, 20'hABCDE, 0, "R8");
        fetch(PA, 12'h104, 1, "R8");
        chk("R8", "ra after delivery", ra_out, {20'hABCDE, 12'h104});
        fetch(PA, 12'hFFC, 2, "R3");
        // R2: bypass
        xlate_en = 0;
        fetch(20'h77777, 12'h123, 2, "R2");
        chk("R2", "ra bypass", ra_out, 32'h77777123);
        xlate_en = 1;
        // R11: delivery in idle touches only the TLB; then R4 bubble count
        pte(PB, 20'h11111, 0, "R11");
        fa_req = 1; fa_ea = {PB, 12'h008}; lows = 0;
        for (int i = 0; i < 6; i++) begin
            step("R11");
            if (last_req) break;
            lows++;
        end
        fa_req = 0;
        chk("R4", "bubble cycles", lows, 32'd2);
        // R5: replacement order
        fetch(PA, 12'h000, 1, "R5");
        pte(PC, 20'h33333, 0, "R5");
        fetch(PC, 12'h010, 3, "R5");
        fetch(PA, 12'h000, 1, "R5");
        fetch(PB, 12'h000, 3, "R5");
        fetch(PC, 12'h000, 3, "R5");
        // R10: invalidate empties the slots
        inval = 1; step("R10"); inval = 0;
        fetch(PA, 12'h000, 1, "R10");
        chk("R10", "miss after inval", {31'b0, last_req}, 32'd0);
        fetch(PA, 12'h000, 2, "R7");
        // R9: redirect releases the failure
        redirect = 1; step("R9"); redirect = 0;
        chk("R9", "fail cleared", {31'b0, fetch_fail}, 32'd0);
        // R6: collision in the TLB index
        pte(PA, 20'h0AAAA, 0, "R6");
        fetch(PA, 12'h000, 3, "R6");
        pte(PD, 20'h0DDDD, 0, "R6");
        inval = 1; step("R6"); inval = 0;
        pte(PD, 20'h0DDDD, 0, "R6");
        fetch(PA, 12'h000, 4, "R6");
        chk("R6", "collision fault", {31'b0, fetch_fail}, 32'd1);
        intr = 1; step("R9"); intr = 0;
        fetch(PD, 12'h444, 3, "R6");
        chk("R6", "collider hit", ra_out, {20'h0DDDD, 12'h444});
        // R7/R8: no-execute entry, no-execute delivery keeps the failure
        pte(PC, 20'h33333, 1, "R7");
        fetch(PC, 12'h000, 4, "R7");
        fa_req = 1; fa_ea = {PC, 12'h000};
        pte(PC, 20'h33333, 1, "R8");
        step("R8");
        chk("R8", "noexec keeps fail", {31'b0, fetch_fail}, 32'd1);
        fa_req = 0;
        // R10: invalidate beats delivery in the same cycle
        inval = 1; pte(PC, 20'h3C3C3, 0, "R10"); inval = 0;
        step("R10");
        chk("R10", "fail after inval+pte", {31'b0, fetch_fail}, 32'd1);
        intr = 1; step("R9"); intr = 0;
        // R9: redirect during lookup, no fill
        pte(PB, 20'h11111, 0, "R9");
        fetch(PB, 12'h000, 1, "R9");
        redirect = 1; fetch(PB, 12'h000, 1, "R9"); redirect = 0;
        fetch(PB, 12'h000, 1, "R9");
        chk("R9", "no fill after abort", {31'b0, last_req}, 32'd0);
        fetch(PB, 12'h000, 2, "R9");
        // R10: invalidate during lookup aborts
        inval = 1; step("R10"); inval = 0;
        pte(PB, 20'h11111, 0, "R10");
        fetch(PB, 12'h000, 1, "R10");
        inval = 1; fetch(PB, 12'h000, 1, "R10"); inval = 0;
        fetch(PB, 12'h000, 3, "R10");
        quiet();
        // mixed pseudo-random traffic against the reference
        pages[0] = PA; pages[1] = PB; pages[2] = PC; pages[3] = PD;
        pages[4] = 20'h00041; pages[5] = 20'hFFFFF;
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            quiet();
            xlate_en = (lfsr[2:0] != 3'd0);
            fa_req   = (lfsr[5:3] != 3'd0);
            if (last_req || !fa_req) fa_ea = {pages[lfsr[8:6] % 6], lfsr[15:4]};
            if (lfsr[11:8] == 4'd3) inval = 1;
            if (lfsr[12:9] == 4'd5) redirect = 1;
            if (lfsr[14:12] == 3'd1 || (fetch_fail && lfsr[1])) begin
                pte_we = 1; pte_pn = pages[lfsr[15:13] % 6];
                pte_rpn = {lfsr[3:0], lfsr}; pte_noexec = (lfsr[10:9] == 2'd0);
            end
            step("");
        end
        quiet();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule